// File: doc/BRIEF.md
# HDLC Preamble Insertion Sequencer

This block chooses what the HDLC transmit bit serializer places on the line between frames. While no frame is waiting, it sends interframe time fill, either repeated flag bytes or continuous ones. When a frame becomes ready, the sequencer finishes the fill byte in progress. If preamble insertion is enabled, it then sends an 8-bit user pattern a programmed number of times. After that it passes the line to the downstream frame path, which supplies the opening flag and the frame body.

Bits leave least significant first, one for each bit-clock enable. While the pattern is on the line, a status output is high so that the checksum generator can hold its state. The pattern is not part of the frame and must stay out of the CRC. During a frame the sequencer forwards the frame path's serial bit unchanged. A frame-end strobe returns it to idle fill.

Top module: `hdlc_preamble_seq`

## Requirements
- R1: After reset the sequencer is in idle fill with `pre_active` and `frame_active` low, and the first fill bit (bit 0) is on `tx_bit`.
- R2: In idle fill, `tx_bit` carries the fill byte LSB first and advances one bit per cycle with `bit_en` high. The fill byte is 0x7E when `idle_flags`=1 and 0xFF when `idle_flags`=0.
- R3: A `frame_ready` strobe may arrive in any cycle of idle fill, including mid-byte. The request is held, and the fill byte continues until its bit 7 has been sent. The change of state takes effect at the clock edge where that bit_en cycle ends.
- R4: When `pre_en`=1 at that byte boundary, the sequencer sends `pre_pattern` LSB first, `pre_reps`+1 times in a row (`pre_reps` is 3 bits, so 1 to 8 copies). It then raises `frame_active`.
- R5: When `pre_en`=0 at that byte boundary, `frame_active` rises directly after the fill byte and `pre_active` never asserts.
- R6: `pre_active` is high in exactly those cycles in which a preamble bit is on `tx_bit`. It is never high together with `frame_active`.
- R7: The pattern and the repetition count are captured when the preamble starts. Changing `pre_pattern` or `pre_reps` during the preamble has no effect on the bits sent or on their number.
- R8: While `frame_active` is high, `tx_bit` equals `frame_bit`. A `frame_end` strobe returns the sequencer to idle fill at fill bit 0 on the next cycle. A `frame_ready` strobe outside idle fill is ignored.
- R9: In a cycle with `bit_en` low, neither the fill position nor the preamble position advances. `tx_bit` holds its value.
- R10: `tx_valid` marks every cycle in which `tx_bit` is consumed by the line, which is every cycle with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| idle_flags | input | 1 | Fill select: 1 = flag bytes 0x7E, 0 = all ones |
| frame_ready | input | 1 | Strobe: a new frame is ready to send |
| pre_en | input | 1 | Preamble insertion enable |
| pre_pattern | input | 8 | Preamble pattern, sent LSB first |
| pre_reps | input | 3 | Copies of the pattern minus one |
| frame_bit | input | 1 | Serial bit from the frame path |
| frame_end | input | 1 | Strobe: frame path has finished |
| tx_bit | output | 1 | Serial line bit |
| tx_valid | output | 1 | Line bit is consumed this cycle |
| pre_active | output | 1 | Preamble on the line; hold the CRC |
| frame_active | output | 1 | Line handed to the frame path |

## Verification
The bench builds the block with its fixed 8-bit pattern width and 3-bit count. This makes both count extremes, one copy and eight copies, reachable in short runs. The bench drives `bit_en` at full rate, at half rate and in long low stretches. This places frame requests at several bit positions inside a fill byte and makes stalls in the middle of the preamble visible. A behavioural model built from queues compares the line bit and both status outputs on every clock. The runs include changes to the pattern registers in the middle of the preamble and requests during frames.

// File: rtl/hdlc_preamble_seq.sv
module hdlc_preamble_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       idle_flags,
  input  logic       frame_ready,
  input  logic       pre_en,
  input  logic [7:0] pre_pattern,
  input  logic [2:0] pre_reps,
  input  logic       frame_bit,
  input  logic       frame_end,
  output logic       tx_bit,
  output logic       tx_valid,
  output logic       pre_active,
  output logic       frame_active
);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_FRAME} state_t;

  state_t     state;
  logic [2:0] bit_cnt;
  logic [2:0] rep_cnt;
  logic [2:0] reps_l;
  logic [7:0] pat_l;
  logic       pend;
  logic [6:0] pre_bits;

  wire       req      = pend | frame_ready;
  wire       byte_end = bit_en && (bit_cnt == 3'd7);
  wire [7:0] fill     = idle_flags ? 8'h7E : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_cnt <= 3'd0;
      rep_cnt <= 3'd0;
      reps_l  <= 3'd0;
      pat_l   <= 8'h00;
      pend    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (frame_ready) pend <= 1'b1;
          if (bit_en) bit_cnt <= bit_cnt + 3'd1;
          if (byte_end && req) begin
            pend    <= 1'b0;
            rep_cnt <= 3'd0;
            if (pre_en) begin
              state  <= S_PRE;
              pat_l  <= pre_pattern;
              reps_l <= pre_reps;
            end else begin
              state <= S_FRAME;
            end
          end
        end
        S_PRE: begin
          if (bit_en) bit_cnt <= bit_cnt + 3'd1;
          if (byte_end) begin
            if (rep_cnt == reps_l) state <= S_FRAME;
            else rep_cnt <= rep_cnt + 3'd1;
          end
        end
        default: begin
          if (frame_end) begin
            state   <= S_IDLE;
            bit_cnt <= 3'd0;
          end
        end
      endcase
    end
  end

  assign pre_active   = (state == S_PRE);
  assign frame_active = (state == S_FRAME);
  assign tx_valid     = bit_en;
  assign tx_bit       = frame_active ? frame_bit :
                        pre_active   ? pat_l[bit_cnt] : fill[bit_cnt];

  always_ff @(posedge clk) begin
    if (!rst_n || !pre_active) pre_bits <= 7'd0;
    else if (bit_en) pre_bits <= pre_bits + 7'd1;
  end

  AST_PRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_active) |-> $past(pre_en) && $past(bit_en)); // R4
  AST_DIRECT_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(bit_en) && ($past(pre_active) || !$past(pre_en))); // R5
  AST_PRE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_active) |-> (int'($past(pre_bits)) == 8 * (int'($past(reps_l)) + 1) - 1)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_active && !bit_en) |=> pre_active && $stable(tx_bit)); // R9
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && frame_end) |=> !frame_active && !pre_active); // R8
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_active && frame_active)); // R6

endmodule

// File: tb/hdlc_preamble_seq_bench.sv
module hdlc_preamble_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, idle_flags = 1'b1, frame_ready = 1'b0, pre_en = 1'b0;
  logic [7:0] pre_pattern = 8'h00;
  logic [2:0] pre_reps = 3'd0;
  logic frame_bit = 1'b0, frame_end = 1'b0;
  logic tx_bit, tx_valid, pre_active, frame_active;

  hdlc_preamble_seq u_hdlc_preamble_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .idle_flags(idle_flags),
    .frame_ready(frame_ready), .pre_en(pre_en), .pre_pattern(pre_pattern),
    .pre_reps(pre_reps), .frame_bit(frame_bit), .frame_end(frame_end),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .pre_active(pre_active),
    .frame_active(frame_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  int m_st = 0, m_pos = 0, m_pend = 0;
  bit q[$];
  int pre_seen = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] f;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_pend = 0; q.delete();
    end else begin
      case (m_st)
        0: begin
          if (frame_ready) m_pend = 1;
          if (bit_en) begin
            if (m_pos == 7 && m_pend) begin
              m_pos = 0; m_pend = 0;
              if (pre_en) begin
                for (int r = 0; r <= int'(pre_reps); r++)
                  for (int b = 0; b < 8; b++) q.push_back(pre_pattern[b]);
                m_st = 1;
              end else m_st = 2;
            end else m_pos = (m_pos + 1) % 8;
          end
        end
        1: if (bit_en) begin
             void'(q.pop_front());
             if (q.size() == 0) m_st = 2;
           end
        default: if (frame_end) begin m_st = 0; m_pos = 0; end
      endcase
    end
    f = 8'h00;
    if (cyc == 150000) begin
      check("R1", "watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [7:0] fill;
    int eb;
    if (rst_n) begin
      fill = idle_flags ? 8'h7E : 8'hFF;
      eb = (m_st == 2) ? int'(frame_bit) : (m_st == 1) ? int'(q[0]) : int'(fill[m_pos]);
      if (pre_active) pre_seen = 1;
      check(cur_req, "tx_bit", int'(tx_bit), eb);
      check("R6", "pre_active", int'(pre_active), int'(m_st == 1));
      check(cur_req, "frame_active", int'(frame_active), int'(m_st == 2));
      check("R10", "tx_valid", int'(tx_valid), int'(bit_en));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_frame(int half);
    int k = 0;
    while (m_st != 2 && k < 2000) begin
      bit_en = half ? ~bit_en : 1'b1;
      frame_bit = ~frame_bit;
      step(1); k++;
    end
  endtask

  task automatic run_frame(int n);
    for (int i = 0; i < n; i++) begin frame_bit = i[0] ^ i[2]; step(1); end
    frame_end = 1'b1; step(1); frame_end = 1'b0;
  endtask

  task automatic pulse_ready;
    frame_ready = 1'b1; step(1); frame_ready = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    check("R1", "reset pre_active", int'(pre_active), 0);
    check("R1", "reset frame_active", int'(frame_active), 0);
    check("R1", "reset tx_bit (0x7E bit0)", int'(tx_bit), 0);

    cur_req = "R2"; bit_en = 1'b1; step(20);
    idle_flags = 1'b0; step(16); idle_flags = 1'b1; step(8);

    cur_req = "R3"; step(3); pre_en = 1'b1; pre_pattern = 8'hA5; pre_reps = 3'd2;
    pulse_ready; bit_en = 1'b0; step(2);
    cur_req = "R4"; wait_frame(1);
    cur_req = "R8"; run_frame(9);

    cur_req = "R5"; pre_seen = 0; pre_en = 1'b0; bit_en = 1'b1; step(5);
    pulse_ready; wait_frame(0);
    check("R5", "pre_active seen", pre_seen, 0);
    run_frame(6);

    cur_req = "R4"; pre_en = 1'b1; pre_reps = 3'd0; pre_pattern = 8'h3C; step(2);
    pulse_ready; wait_frame(0); run_frame(4);
    pre_reps = 3'd7; pre_pattern = 8'h81; pulse_ready; wait_frame(0); run_frame(4);

    cur_req = "R7"; pre_reps = 3'd1; pre_pattern = 8'hC3; pulse_ready;
    while (m_st != 1) step(1);
    step(3); pre_pattern = 8'h0F; pre_reps = 3'd6;
    wait_frame(0); run_frame(3);

    cur_req = "R9"; pre_reps = 3'd1; pre_pattern = 8'h96; pulse_ready;
    while (m_st != 1) step(1);
    step(5); bit_en = 1'b0; step(30); bit_en = 1'b1;
    wait_frame(0);

    cur_req = "R8"; step(2); pulse_ready; run_frame(5);
    step(40);
    check("R8", "frame_ready in frame ignored", int'(frame_active || pre_active), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule